// File: doc/BRIEF.md
# Reset Root-Cause Capture

This block merges every reset request in an always-on domain into one system reset line. It also keeps a 3-bit code that records which request started the most recent reset. The requests are power-on, the external reset pin, brown-out on supply A, brown-out on supply B, clock loss, a software cold reset, a power-management timeout and a warm reset. The block runs on a fast clock. A one-cycle `slow_tick` pulse marks each period of a slower timebase, and that timebase paces the copy of the captured code, the re-arm of the capture and the stretch of the reset output.

Software reaches the block through a small write/read port. Through it, software can:
- gate the supply-A, supply-B and clock-loss requests;
- request a cold reset;
- hold the wake-from-shutdown flags clear with the pad-sleep-disable control;
- read back the captured cause and both wake flags.

The block records only the first request of an episode. It re-arms only after every request has gone away and the result has been copied to status. For one slow period after that copy, any new request is recorded as power-on.

Top module: `rstcause_top`

## Requirements
- R1: Cause codes are: power-on 0, pin 1, supply-A brown-out 2, supply-B brown-out 4, clock loss 5, software cold reset or power-management timeout 6, warm reset 7. Code 3 is never reported.
- R2: While the capture is armed, the first request to arrive is recorded. Requests that arrive later in the same episode do not change the record.
- R3: If several requests first arrive in the same cycle, the one with the lowest code is recorded.
- R4: The recorded code reaches `cause_code` on the first `slow_tick` on which no request is active. While any request stays active, the code is not copied and the capture does not re-arm.
- R5: After a copy, the capture stays blind until the next `slow_tick`. A request that arrives in that window is recorded as code 0.
- R6: Control register (address 0) bits 0, 1 and 2 enable supply-A, supply-B and clock-loss requests. The reset value of these three bits is 1. When a bit is 0, its request causes no reset and is not recorded.
- R7: Writing address 0 with bit 7 set produces a system reset recorded as code 6. A write with bit 7 clear has no effect on the reset line. Bit 7 always reads as 0.
- R8: The power-management timeout request cannot be gated, and it is recorded as code 6.
- R9: `sys_rst` rises one cycle after any enabled request. It stays high until two `slow_tick` pulses have passed with no request active.
- R10: `wake_io_evt` sets both wake flags. `wake_sd_evt` sets only `wake_sd_flag`. While control bit 3 (pad-sleep disable) is 1, both flags are cleared and stay clear.
- R11: `bus_rdata` returns, one cycle after the address is presented, the following:
  - address 0: control bits [3:0];
  - address 1: status, with bits [2:0] the cause, bit 3 `wake_sd_flag` and bit 4 `wake_io_flag`;
  - any other address: 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| rst | input | 1 | Synchronous active-high reset of this block |
| slow_tick | input | 1 | One-cycle pulse per slow timebase period |
| por_req | input | 1 | Power-on request |
| pin_req | input | 1 | External pin request |
| bod_a_req | input | 1 | Supply-A brown-out request |
| bod_b_req | input | 1 | Supply-B brown-out request |
| clk_loss_req | input | 1 | Clock-loss request |
| pm_timeout_req | input | 1 | Power-management timeout request |
| warm_req | input | 1 | Warm reset request |
| wake_sd_evt | input | 1 | Wake from shutdown, any cause |
| wake_io_evt | input | 1 | Wake from shutdown caused by an IO event |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| sys_rst | output | 1 | Combined system reset |
| cause_code | output | 3 | Captured cause code |
| wake_sd_flag | output | 1 | Wake-from-shutdown flag |
| wake_io_flag | output | 1 | IO-event wake flag |

## Verification
The assertions check on every cycle that:
- code 3 never appears;
- an ungated request raises `sys_rst` on the next cycle;
- the cause changes only after a slow tick;
- the wake flags are cleared while pad-sleep disable is set, and the IO flag never stands without the general flag.

Some behaviour depends on the order of events across many cycles, and only the bench scenarios can show it:
- which of several requests wins;
- that a request still held blocks the copy;
- the blind window that records power-on;
- the gating by the enable bits;
- the two-tick stretch of `sys_rst`;
- the register readback.

// File: rtl/rstcause_pkg.sv
package rstcause_pkg;
  localparam int CODE_W = 3;
  localparam int NSRC   = 1 << CODE_W;

  typedef logic [CODE_W-1:0] cause_t;

  localparam cause_t C_POWERON  = 3'd0;
  localparam cause_t C_PIN      = 3'd1;
  localparam cause_t C_SUPPLY_A = 3'd2;
  localparam cause_t C_SUPPLY_B = 3'd4;
  localparam cause_t C_CLKLOSS  = 3'd5;
  localparam cause_t C_COLD     = 3'd6;
  localparam cause_t C_WARM     = 3'd7;

  typedef enum logic [1:0] {ST_ARMED, ST_HELD, ST_BLIND} cap_state_e;

  // control register bit positions
  localparam int CB_EN_A    = 0;
  localparam int CB_EN_B    = 1;
  localparam int CB_EN_CLK  = 2;
  localparam int CB_PAD_DIS = 3;
  localparam int CB_COLD    = 7;
  localparam int CTRL_BITS  = 4;
endpackage

// File: rtl/rstcause_regs.sv
module rstcause_regs
  import rstcause_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] status_in,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              en_a,
  output logic              en_b,
  output logic              en_clk,
  output logic              pad_dis,
  output logic              cold_pulse
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);

  logic [CTRL_BITS-1:0] ctrl_q;
  logic [DATA_W-1:0]    ctrl_view;
  logic                 wr_ctrl;

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= CTRL_BITS'(4'b0111);
      cold_pulse <= 1'b0;
    end else begin
      cold_pulse <= wr_ctrl && bus_wdata[CB_COLD];
      if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_BITS-1:0];
    end
  end

  always_comb begin
    ctrl_view                  = '0;
    ctrl_view[CTRL_BITS-1:0]   = ctrl_q;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (bus_addr)
        A_CTRL:  bus_rdata <= ctrl_view;
        A_STAT:  bus_rdata <= status_in;
        default: bus_rdata <= '0;
      endcase
    end
  end

  assign en_a    = ctrl_q[CB_EN_A];
  assign en_b    = ctrl_q[CB_EN_B];
  assign en_clk  = ctrl_q[CB_EN_CLK];
  assign pad_dis = ctrl_q[CB_PAD_DIS];
endmodule

// File: rtl/rstcause_capture.sv
module rstcause_capture
  import rstcause_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic [NSRC-1:0] req,
  output cause_t          cause_q
);
  cap_state_e st;
  cause_t     held;
  cause_t     first_code;
  logic       any_req;

  assign any_req = |req;

  // lowest active index wins
  always_comb begin
    first_code = C_POWERON;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) first_code = cause_t'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_ARMED;
      held    <= C_POWERON;
      cause_q <= C_POWERON;
    end else begin
      case (st)
        ST_ARMED: if (any_req) begin
          held <= first_code;
          st   <= ST_HELD;
        end
        ST_HELD: if (!any_req && tick) begin
          cause_q <= held;
          st      <= ST_BLIND;
        end
        ST_BLIND: if (any_req) begin
          held <= C_POWERON;
          st   <= ST_HELD;
        end else if (tick) begin
          st <= ST_ARMED;
        end
        default: st <= ST_ARMED;
      endcase
    end
  end
endmodule

// File: rtl/rstcause_hold.sv
module rstcause_hold #(
  parameter int HOLD_TICKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic any_req,
  output logic sys_rst
);
  localparam int HOLD_W = $clog2(HOLD_TICKS + 1);

  logic [HOLD_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      sys_rst <= 1'b0;
    end else begin
      if (any_req)                cnt <= HOLD_W'(HOLD_TICKS);
      else if (tick && cnt != '0) cnt <= cnt - 1'b1;
      sys_rst <= any_req || (cnt != '0);
    end
  end
endmodule

// File: rtl/rstcause_top.sv
module rstcause_top
  import rstcause_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 2,
  parameter int HOLD_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slow_tick,
  input  logic              por_req,
  input  logic              pin_req,
  input  logic              bod_a_req,
  input  logic              bod_b_req,
  input  logic              clk_loss_req,
  input  logic              pm_timeout_req,
  input  logic              warm_req,
  input  logic              wake_sd_evt,
  input  logic              wake_io_evt,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sys_rst,
  output logic [2:0]        cause_code,
  output logic              wake_sd_flag,
  output logic              wake_io_flag
);
  logic            en_a, en_b, en_clk, pad_dis, cold_pulse;
  logic [NSRC-1:0] req;
  logic [DATA_W-1:0] status;
  cause_t          cause_q;

  always_comb begin
    req             = '0;
    req[C_POWERON]  = por_req;
    req[C_PIN]      = pin_req;
    req[C_SUPPLY_A] = bod_a_req & en_a;
    req[C_SUPPLY_B] = bod_b_req & en_b;
    req[C_CLKLOSS]  = clk_loss_req & en_clk;
    req[C_COLD]     = pm_timeout_req | cold_pulse;
    req[C_WARM]     = warm_req;
  end

  always_ff @(posedge clk) begin
    if (rst || pad_dis) begin
      wake_sd_flag <= 1'b0;
      wake_io_flag <= 1'b0;
    end else begin
      if (wake_io_evt) begin
        wake_io_flag <= 1'b1;
        wake_sd_flag <= 1'b1;
      end
      if (wake_sd_evt) wake_sd_flag <= 1'b1;
    end
  end

  always_comb begin
    status        = '0;
    status[2:0]   = cause_q;
    status[3]     = wake_sd_flag;
    status[4]     = wake_io_flag;
  end

  rstcause_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .status_in(status), .bus_rdata(bus_rdata),
    .en_a(en_a), .en_b(en_b), .en_clk(en_clk), .pad_dis(pad_dis),
    .cold_pulse(cold_pulse)
  );

  rstcause_capture u_cap (
    .clk(clk), .rst(rst), .tick(slow_tick), .req(req), .cause_q(cause_q)
  );

  rstcause_hold #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk(clk), .rst(rst), .tick(slow_tick), .any_req(|req), .sys_rst(sys_rst)
  );

  assign cause_code = cause_q;
endmodule

// File: rtl/rstcause_checker.sv
module rstcause_checker (
  input logic       clk,
  input logic       rst,
  input logic       slow_tick,
  input logic       hard_req,
  input logic       pad_dis,
  input logic       sys_rst,
  input logic [2:0] cause_code,
  input logic       wake_sd_flag,
  input logic       wake_io_flag
);
  assert_no_code3_R1: assert property (@(posedge clk) disable iff (rst)
    cause_code != 3'd3);

  assert_req_raises_rst_R9: assert property (@(posedge clk) disable iff (rst)
    hard_req |=> sys_rst);

  assert_copy_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(cause_code)) |-> $past(slow_tick));

  assert_pad_clears_R10: assert property (@(posedge clk) disable iff (rst)
    pad_dis |=> (!wake_sd_flag && !wake_io_flag));

  assert_io_implies_sd_R10: assert property (@(posedge clk) disable iff (rst)
    wake_io_flag |-> wake_sd_flag);
endmodule

bind rstcause_top rstcause_checker u_chk (
  .clk(clk), .rst(rst), .slow_tick(slow_tick),
  .hard_req(por_req | pin_req | pm_timeout_req | warm_req),
  .pad_dis(pad_dis), .sys_rst(sys_rst), .cause_code(cause_code),
  .wake_sd_flag(wake_sd_flag), .wake_io_flag(wake_io_flag)
);

// File: tb/rstcause_top_test.sv
module rstcause_top_test;
  localparam int CLK_P = 10;
  localparam int DW = 8;
  localparam int AW = 2;

  logic clk = 0, rst = 1, slow_tick = 0;
  logic por_req = 0, pin_req = 0, bod_a_req = 0, bod_b_req = 0;
  logic clk_loss_req = 0, pm_timeout_req = 0, warm_req = 0;
  logic wake_sd_evt = 0, wake_io_evt = 0, bus_wr = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic sys_rst, wake_sd_flag, wake_io_flag;
  logic [2:0] cause_code;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct { int kind; int exp; string tag; } item_t;
  item_t sb[$];

  always #(CLK_P/2) clk = ~clk;

  rstcause_top #(.DATA_W(DW), .ADDR_W(AW), .HOLD_TICKS(2)) uut (.*);

  // monitor: compares every queued expectation at the falling edge
  initial forever begin
    @(negedge clk);
    while (sb.size() > 0) begin
      item_t it;
      int act;
      it = sb.pop_front();
      case (it.kind)
        0: act = int'(cause_code);
        1: act = int'(sys_rst);
        2: act = int'(wake_sd_flag);
        3: act = int'(wake_io_flag);
        default: act = int'(bus_rdata);
      endcase
      n_chk++;
      if (act != it.exp) begin
        n_fail++;
        $display("FAIL %s kind=%0d actual=%0d expected=%0d", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic expect_v(input int kind, input int exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic tick();
    slow_tick = 1; cyc(1); slow_tick = 0; cyc(1);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1; cyc(1); bus_wr = 0;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    cyc(3); rst = 0; cyc(1);
    expect_v(0, 0, "reset cause R1");
    expect_v(1, 0, "reset sys_rst R9");
    expect_v(2, 0, "reset wake R10");

    // R2: first to assert wins
    warm_req = 1; cyc(1); pin_req = 1; cyc(2);
    warm_req = 0; pin_req = 0; cyc(1);
    tick(); expect_v(0, 7, "first wins R2");
    tick();

    // R3: same-cycle tie, lower code
    pin_req = 1; clk_loss_req = 1; cyc(2);
    pin_req = 0; clk_loss_req = 0; cyc(1);
    tick(); expect_v(0, 1, "tie pin/clk R3");
    tick();
    bod_a_req = 1; bod_b_req = 1; cyc(2);
    bod_a_req = 0; bod_b_req = 0; cyc(1);
    tick(); expect_v(0, 2, "tie supply A/B R3");
    tick();

    // R4: held request blocks copy
    warm_req = 1; cyc(2); tick(); tick();
    expect_v(0, 2, "no copy while held R4");
    warm_req = 0; cyc(1); tick();
    expect_v(0, 7, "copy after release R4");
    tick();

    // R6: gated sources
    wr(0, 8'h00);
    bod_a_req = 1; bod_b_req = 1; clk_loss_req = 1; cyc(3);
    expect_v(1, 0, "disabled no reset R6");
    tick(); tick();
    expect_v(0, 7, "disabled no capture R6");
    bod_a_req = 0; bod_b_req = 0; clk_loss_req = 0;
    wr(0, 8'h07); cyc(2);
    expect_v(1, 0, "cold bit zero no effect R7");

    // R7: software cold reset
    wr(0, 8'h87); cyc(1);
    expect_v(1, 1, "cold write resets R7");
    cyc(1); tick(); expect_v(0, 6, "cold code R7");
    tick();
    bus_addr = 0; cyc(2); expect_v(4, 8'h07, "cold bit reads 0 R7");

    // R1/R9: pin reset and stretch
    pin_req = 1; cyc(2); expect_v(1, 1, "pin asserts R9");
    pin_req = 0; cyc(1); expect_v(1, 1, "stretch after release R9");
    tick(); expect_v(0, 1, "pin code R1");
    expect_v(1, 1, "stretch after one tick R9");
    tick(); expect_v(1, 0, "release after two ticks R9");

    // R8: power-management timeout
    pm_timeout_req = 1; cyc(2); pm_timeout_req = 0; cyc(1);
    tick(); expect_v(0, 6, "timeout code R8"); tick();

    // R1: other codes
    bod_b_req = 1; cyc(2); bod_b_req = 0; cyc(1);
    tick(); expect_v(0, 4, "supply B code R1"); tick();
    clk_loss_req = 1; cyc(2); clk_loss_req = 0; cyc(1);
    tick(); expect_v(0, 5, "clock loss code R1"); tick();

    // R5: blind window
    pin_req = 1; cyc(2); pin_req = 0; cyc(1);
    tick(); expect_v(0, 1, "before blind R5");
    warm_req = 1; cyc(2); warm_req = 0; cyc(1);
    tick(); expect_v(0, 0, "blind forces power-on R5");
    tick(); tick();

    // R10: wake flags
    wake_io_evt = 1; cyc(1); wake_io_evt = 0; cyc(1);
    expect_v(2, 1, "io sets general R10");
    expect_v(3, 1, "io sets io R10");
    wr(0, 8'h0F); cyc(1);
    expect_v(2, 0, "pad dis clears sd R10");
    expect_v(3, 0, "pad dis clears io R10");
    wake_sd_evt = 1; cyc(1); wake_sd_evt = 0; cyc(1);
    expect_v(2, 0, "held clear R10");
    wr(0, 8'h07);
    wake_sd_evt = 1; cyc(1); wake_sd_evt = 0; cyc(1);
    expect_v(2, 1, "sd sets general R10");
    expect_v(3, 0, "sd leaves io R10");

    // R11: readback
    bus_addr = 1; cyc(2); expect_v(4, 8'h08, "status read R11");
    bus_addr = 0; cyc(2); expect_v(4, 8'h07, "ctrl read R11");
    bus_addr = 2; cyc(2); expect_v(4, 0, "unused read R11");

    cyc(2);
    done = 1;
    report();
  end
endmodule